// File: doc/BRIEF.md
# Signed-Magnitude Adder-Subtractor

This block adds or subtracts two operands held in signed-magnitude form. Each operand is a `W`-bit magnitude with a separate sign bit, and one select input picks addition or subtraction. The block compares the two signs with an XOR and combines the result with the operation select. From that it decides whether the magnitudes are summed or differenced. All arithmetic goes through one ripple adder with an XOR complementer on its second input. The complementer control also serves as the adder carry-in.

An operation begins with a one-cycle `start` pulse while the block is idle. The block then latches the operands and runs one or two internal steps. The first step is the main add or subtract. The second step runs only on the difference path and fixes up a negative result by two's-complementing the magnitude and flipping the sign. A one-cycle `done` pulse marks the point where the result magnitude, the result sign and the overflow flag are valid. These outputs then hold until the next operation begins.

Top module: `smas_addsub`

## Requirements
- R1: After reset, `busy`, `done`, `res_sign`, `ovf` and `res_mag` are all 0.
- R2: A `start` seen at a clock edge while idle latches the operands. `busy` is high from the next cycle until `done` falls. `done` is high for exactly one cycle: in the second cycle after the start edge on the magnitude-sum path, and in the third cycle on the difference path.
- R3: The magnitude-sum path is taken when `op_sub`=0 and the signs are equal, or when `op_sub`=1 and the signs differ. It gives `res_mag` = (`a_mag` + `b_mag`) mod 2^W and `res_sign` = `a_sign`.
- R4: On the magnitude-sum path, `ovf` equals the carry out of the W-bit sum, so it is 1 exactly when `a_mag` + `b_mag` >= 2^W.
- R5: On the difference path with `a_mag` > `b_mag`, `res_mag` = `a_mag` - `b_mag` and `res_sign` = `a_sign`.
- R6: On the difference path with `a_mag` < `b_mag`, `res_mag` = `b_mag` - `a_mag` and `res_sign` is the inverse of `a_sign`.
- R7: On the difference path with equal magnitudes, `res_mag` = 0 and `res_sign` = 0, whatever the operand signs are.
- R8: On the difference path, `ovf` is 0 when `done` is high, even if the previous operation overflowed.
- R9: A `start` pulse while `busy` is high has no effect. The running operation's result and latency are unchanged.
- R10: While idle and with no `start`, `res_mag`, `res_sign` and `ovf` keep their values, and `done` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (accepted only when idle) |
| op_sub | input | 1 | 0 = add, 1 = subtract B from A |
| a_sign | input | 1 | Sign of operand A (1 = negative) |
| a_mag | input | W | Magnitude of operand A |
| b_sign | input | 1 | Sign of operand B (1 = negative) |
| b_mag | input | W | Magnitude of operand B |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: result valid |
| res_sign | output | 1 | Sign of the result |
| res_mag | output | W | Magnitude of the result |
| ovf | output | 1 | Carry out of a magnitude sum |

## Verification
The assertions assume that `start`, `op_sub` and the operand inputs are stable across each rising edge. They also assume that `rst_n` is asserted before the first edge, so the control state begins in idle. The bench meets these assumptions by changing every input only on falling edges and by holding reset for several cycles at the start. It deliberately raises `start` while the block is busy, because that case must be covered by the ignore rule rather than by any assumption.

// File: rtl/smas_pkg.sv
package smas_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EXEC = 2'd1,
    ST_FIX  = 2'd2,
    ST_DONE = 2'd3
  } smas_state_e;

  // 1 selects the difference path: effective subtraction of magnitudes
  function automatic logic diff_path(input logic sa, input logic sb, input logic op);
    logic signs_differ;
    signs_differ = sa ^ sb;
    return signs_differ ^ op;
  endfunction

  // sign to report after the fix-up step of the difference path
  function automatic logic fixed_sign(input logic sign_in, input logic carry, input logic is_zero);
    logic s;
    if (!carry)       s = ~sign_in;
    else if (is_zero) s = 1'b0;
    else              s = sign_in;
    return s;
  endfunction

endpackage

// File: rtl/smas_complementer.sv
module smas_complementer #(
  parameter int W = 8
) (
  input  logic [W-1:0] b_in,
  input  logic         m,
  output logic [W-1:0] b_out
);
  for (genvar i = 0; i < W; i++) begin : g_xor
    assign b_out[i] = b_in[i] ^ m;
  end
endmodule

// File: rtl/smas_adder.sv
module smas_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] c;
  assign c[0] = cin;
  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum[i]  = x[i] ^ y[i] ^ c[i];
    assign c[i+1]  = (x[i] & y[i]) | (c[i] & (x[i] ^ y[i]));
  end
  assign cout = c[W];
endmodule

// File: rtl/smas_ctrl.sv
module smas_ctrl
  import smas_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        sub_path,
  output smas_state_e state,
  output logic        load_en,
  output logic        exec_en,
  output logic        fix_en,
  output logic        busy,
  output logic        done
);
  smas_state_e state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: if (start) state_nx = ST_EXEC;
      ST_EXEC: state_nx = sub_path ? ST_FIX : ST_DONE;
      ST_FIX:  state_nx = ST_DONE;
      ST_DONE: state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  assign load_en = (state == ST_IDLE) && start;
  assign exec_en = (state == ST_EXEC);
  assign fix_en  = (state == ST_FIX);
  assign busy    = (state != ST_IDLE);
  assign done    = (state == ST_DONE);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
  AST_SUM_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && !sub_path) |=> done); // R2
  AST_DIFF_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && sub_path) |=> (fix_en && !done)); // R2
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && start) |=> busy); // R9
endmodule

// File: rtl/smas_addsub.sv
module smas_addsub
  import smas_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         op_sub,
  input  logic         a_sign,
  input  logic [W-1:0] a_mag,
  input  logic         b_sign,
  input  logic [W-1:0] b_mag,
  output logic         busy,
  output logic         done,
  output logic         res_sign,
  output logic [W-1:0] res_mag,
  output logic         ovf
);
  localparam logic [W-1:0] ZERO = '0;

  smas_state_e state;
  logic load_en, exec_en, fix_en;

  logic [W-1:0] a_reg, b_reg;
  logic         as_reg, m_reg, e_reg, avf_reg;

  // adder operand steering: exec step uses A and complemented B,
  // fix step forms the two's complement of A as ~A + 0 + 1
  logic [W-1:0] cmp_in, cmp_out, add_x, sum_w;
  logic         cmp_m, add_cin, carry_w;
  logic         a_is_zero;

  assign cmp_in  = fix_en ? ZERO : b_reg;
  assign cmp_m   = fix_en ? 1'b0 : m_reg;
  assign add_x   = fix_en ? ~a_reg : a_reg;
  assign add_cin = fix_en ? 1'b1 : m_reg;
  assign a_is_zero = (a_reg == ZERO);

  smas_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .sub_path (m_reg),
    .state    (state),
    .load_en  (load_en),
    .exec_en  (exec_en),
    .fix_en   (fix_en),
    .busy     (busy),
    .done     (done)
  );

  smas_complementer #(.W(W)) u_cmp (
    .b_in  (cmp_in),
    .m     (cmp_m),
    .b_out (cmp_out)
  );

  smas_adder #(.W(W)) u_add (
    .x    (add_x),
    .y    (cmp_out),
    .cin  (add_cin),
    .sum  (sum_w),
    .cout (carry_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_reg   <= '0;
      b_reg   <= '0;
      as_reg  <= 1'b0;
      m_reg   <= 1'b0;
      e_reg   <= 1'b0;
      avf_reg <= 1'b0;
    end else if (load_en) begin
      a_reg  <= a_mag;
      b_reg  <= b_mag;
      as_reg <= a_sign;
      m_reg  <= diff_path(a_sign, b_sign, op_sub);
    end else if (exec_en) begin
      a_reg   <= sum_w;
      e_reg   <= carry_w;
      avf_reg <= m_reg ? 1'b0 : carry_w;
    end else if (fix_en) begin
      if (!e_reg) a_reg <= sum_w;
      as_reg <= fixed_sign(as_reg, e_reg, a_is_zero);
    end
  end

  assign res_mag  = a_reg;
  assign res_sign = as_reg;
  assign ovf      = avf_reg;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (done && m_reg) |-> !ovf); // R8
  AST_ZERO_POSITIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && m_reg && res_mag == ZERO) |-> !res_sign); // R7
  AST_SIGN_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (fix_en && !e_reg) |=> (res_sign != $past(res_sign))); // R6
  AST_NEG_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (fix_en && !e_reg) |=> (res_mag != ZERO)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(res_mag) && $stable(res_sign) && $stable(ovf))); // R10
endmodule

// File: tb/smas_addsub_tb.sv
module smas_addsub_tb;
  localparam int W = 8;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         op_sub = 1'b0;
  logic         a_sign = 1'b0;
  logic [W-1:0] a_mag = '0;
  logic         b_sign = 1'b0;
  logic [W-1:0] b_mag = '0;
  logic         busy, done, res_sign, ovf;
  logic [W-1:0] res_mag;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smas_addsub #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sub(op_sub),
    .a_sign(a_sign), .a_mag(a_mag), .b_sign(b_sign), .b_mag(b_mag),
    .busy(busy), .done(done), .res_sign(res_sign), .res_mag(res_mag), .ovf(ovf)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one operation; poke = raise start again while busy (R9)
  task automatic run_op(input bit op, input bit as, input int am,
                        input bit bs, input int bm, input string req, input bit poke);
    bit eff_diff, e_sign, e_ovf;
    int e_mag, e_lat, diff, cnt;
    bit hs, ho;
    int hm;
    eff_diff = (as != bs) ? !op : op;
    if (!eff_diff) begin
      e_mag  = (am + bm) % (1 << W);
      e_ovf  = (am + bm) >= (1 << W);
      e_sign = as;
      e_lat  = 2;
    end else begin
      diff   = am - bm;
      e_mag  = (diff < 0) ? -diff : diff;
      e_sign = (diff == 0) ? 1'b0 : ((diff > 0) ? as : !as);
      e_ovf  = 1'b0;
      e_lat  = 3;
    end
    @(negedge clk);
    op_sub = op; a_sign = as; a_mag = W'(am); b_sign = bs; b_mag = W'(bm);
    start = 1'b1;
    cnt = 0;
    forever begin
      @(negedge clk);
      cnt++;
      if (poke && cnt == 1) begin
        start = 1'b1; op_sub = !op; a_mag = ~W'(am); b_mag = ~W'(bm); a_sign = !as;
        check(busy == 1'b1, "R2", "busy while running", int'(busy), 1);
      end else begin
        start = 1'b0;
      end
      if (done || cnt > 20) break;
    end
    start = 1'b0;
    check(cnt == e_lat, req, "latency", cnt, e_lat);
    check(int'(res_mag) == e_mag, req, "res_mag", int'(res_mag), e_mag);
    check(res_sign == e_sign, req, "res_sign", int'(res_sign), int'(e_sign));
    check(ovf == e_ovf, req, "ovf", int'(ovf), int'(e_ovf));
    hm = int'(res_mag); hs = res_sign; ho = ovf;
    repeat (2) @(negedge clk);
    check(!done && !busy, "R2", "done single pulse / idle", int'(done), 0);
    check(int'(res_mag) == hm && res_sign == hs && ovf == ho, "R10", "hold while idle",
          int'(res_mag), hm);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !done && !res_sign && !ovf && res_mag == '0, "R1", "reset outputs",
          int'(res_mag), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done, "R1", "idle after reset", int'(busy), 0);

    // R3 magnitude-sum path
    run_op(1'b0, 1'b0, 5,   1'b0, 7,   "R3", 1'b0);
    run_op(1'b0, 1'b1, 20,  1'b1, 30,  "R3", 1'b0);
    run_op(1'b1, 1'b0, 40,  1'b1, 10,  "R3", 1'b0);
    // R4 overflow on sum
    run_op(1'b0, 1'b0, 200, 1'b0, 100, "R4", 1'b0);
    // R8 ovf cleared by following difference-path op
    run_op(1'b1, 1'b0, 100, 1'b0, 30,  "R8", 1'b0);
    run_op(1'b1, 1'b1, 255, 1'b0, 1,   "R4", 1'b0);
    // R5 difference path, A larger
    run_op(1'b0, 1'b0, 90,  1'b1, 20,  "R5", 1'b0);
    run_op(1'b0, 1'b1, 90,  1'b0, 20,  "R5", 1'b0);
    // R6 difference path, B larger
    run_op(1'b1, 1'b0, 30,  1'b0, 100, "R6", 1'b0);
    run_op(1'b0, 1'b1, 5,   1'b0, 9,   "R6", 1'b0);
    run_op(1'b0, 1'b0, 0,   1'b1, 255, "R6", 1'b0);
    // R7 equal magnitudes give positive zero
    run_op(1'b1, 1'b0, 77,  1'b0, 77,  "R7", 1'b0);
    run_op(1'b0, 1'b1, 77,  1'b0, 77,  "R7", 1'b0);
    // R9 start while busy is ignored
    run_op(1'b0, 1'b0, 12,  1'b0, 3,   "R9", 1'b1);
    run_op(1'b1, 1'b1, 3,   1'b1, 12,  "R9", 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule